// File: doc/BRIEF.md
# Operand-Isolated Execution Unit Cluster

This block is the execute stage of a small 32-bit datapath. It holds three function units (an adder/subtractor, a 16x16 unsigned multiplier and a barrel shifter) and decodes a 4-bit opcode into one-hot unit enables. Only the selected unit sees the real operands. The operand inputs of every other unit are forced to zero with AND gates, so their internal logic does not toggle.

The same enables also drive one supply-level request line per unit. A high line asks for the full supply level and a low line asks for the reduced level. Each instruction therefore acts as its own power control, with no scheduler involved. The opcode and operands are captured on one clock edge, which updates the enables, the requests and the gated operands. The result and the valid flag are captured on the next edge from whichever unit was selected.

Top module: `exu_cluster`

## Requirements
- R1: Opcodes are decoded as follows. ADD=4'h1 and SUB=4'h2 select the adder (unit_en_o bit 0). SLL=4'h3, SRL=4'h4 and SRA=4'h5 select the shifter (bit 1). MUL=4'h6 selects the multiplier (bit 2). The enables reflect the opcode that was present at the previous rising edge.
- R2: ADD returns opa+opb modulo 2^32. SUB returns opa-opb modulo 2^32.
- R3: At most one bit of unit_en_o is high in any cycle.
- R4: Every unit whose enable is low has all of its operand inputs at zero. This holds in every cycle the unit stays idle, not only on the cycle it becomes idle.
- R5: pwr_full_o bit i equals unit_en_o bit i in every cycle. A value of 1 requests the full supply level and 0 requests the reduced level.
- R6: NOP=4'h0 and every undefined opcode (4'h7 to 4'hF) raise no enable and leave all supply requests low. One cycle later they give result_o=0 with valid_o low.
- R7: result_o and valid_o are registered one cycle after the enables. valid_o is high exactly when a unit was enabled in the previous cycle, and the result then comes from that unit.
- R8: MUL uses only the low 16 bits of each operand and returns their 32-bit unsigned product.
- R9: The shift amount is opb[4:0]. SLL and SRL fill vacated bits with zeros. SRA fills them with copies of opa[31].
- R10: While the synchronous active-high reset is high, all enables, supply requests, gated operands, result_o and valid_o are zero at the next edge.
- R11: The selected unit receives the captured operands unchanged. The adder gets opa and opb, the shifter gets opa and opb[4:0], and the multiplier gets opa[15:0] and opb[15:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode_i | input | 4 | Instruction opcode |
| opa_i | input | 32 | Operand A |
| opb_i | input | 32 | Operand B |
| unit_en_o | output | 3 | Unit enables: bit0 adder, bit1 shifter, bit2 multiplier |
| pwr_full_o | output | 3 | Per-unit supply request, 1 = full level, 0 = reduced level |
| add_a_o | output | 32 | Adder operand A after isolation |
| add_b_o | output | 32 | Adder operand B after isolation |
| shf_a_o | output | 32 | Shifter data operand after isolation |
| shf_amt_o | output | 5 | Shifter amount after isolation |
| mul_a_o | output | 16 | Multiplier operand A after isolation |
| mul_b_o | output | 16 | Multiplier operand B after isolation |
| result_o | output | 32 | Registered result |
| valid_o | output | 1 | Result valid |

## Verification
The bench builds the cluster with its default parameters: 32-bit data, a 16-bit multiplier port and a 5-bit shift amount. These values bring several corner cases within reach: carry and borrow wrap at bit 31, arithmetic shifts by 31 that copy the sign bit, and the largest 16-bit product 0xFFFE0001. Operand B values with the upper bits set show that the multiplier and shifter ignore those bits. Back-to-back instructions on different units and repeats of the same instruction show that idle units stay at zero over several cycles while the enables and supply requests move from one unit to the next.

// File: rtl/exu_pkg.sv
package exu_pkg;

    localparam int DATA_W  = 32;
    localparam int MUL_W   = 16;
    localparam int AMT_W   = 5;
    localparam int N_UNITS = 3;

    localparam int U_ADD = 0;
    localparam int U_SHF = 1;
    localparam int U_MUL = 2;

    typedef enum logic [3:0] {
        OP_NOP = 4'h0,
        OP_ADD = 4'h1,
        OP_SUB = 4'h2,
        OP_SLL = 4'h3,
        OP_SRL = 4'h4,
        OP_SRA = 4'h5,
        OP_MUL = 4'h6
    } opcode_e;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_RLOG  = 2'd1,
        SH_RARI  = 2'd2
    } shmode_e;

    typedef struct packed {
        logic [N_UNITS-1:0] en;
        logic               sub;
        shmode_e            shmode;
    } dec_t;

    function automatic dec_t decode_op(input logic [3:0] op);
        dec_t d;
        d = '{en: '0, sub: 1'b0, shmode: SH_LEFT};
        case (op)
            OP_ADD: d.en[U_ADD] = 1'b1;
            OP_SUB: begin d.en[U_ADD] = 1'b1; d.sub = 1'b1; end
            OP_SLL: begin d.en[U_SHF] = 1'b1; d.shmode = SH_LEFT; end
            OP_SRL: begin d.en[U_SHF] = 1'b1; d.shmode = SH_RLOG; end
            OP_SRA: begin d.en[U_SHF] = 1'b1; d.shmode = SH_RARI; end
            OP_MUL: d.en[U_MUL] = 1'b1;
            default: d.en = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/exu_decode.sv
module exu_decode
    import exu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] opcode_i,
    output dec_t       dec_q,
    output logic [N_UNITS-1:0] pwr_q
);
    dec_t dec_d;

    always_comb dec_d = decode_op(opcode_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_q <= '{en: '0, sub: 1'b0, shmode: SH_LEFT};
            pwr_q <= '0;
        end else begin
            dec_q <= dec_d;
            pwr_q <= dec_d.en;
        end
    end
endmodule

// File: rtl/exu_isolate.sv
module exu_isolate
    import exu_pkg::*;
#(
    parameter int DW  = DATA_W,
    parameter int MW  = MUL_W,
    parameter int SW  = AMT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [DW-1:0]      opa_i,
    input  logic [DW-1:0]      opb_i,
    input  logic [N_UNITS-1:0] en_i,
    output logic [DW-1:0]      add_a,
    output logic [DW-1:0]      add_b,
    output logic [DW-1:0]      shf_a,
    output logic [SW-1:0]      shf_amt,
    output logic [MW-1:0]      mul_a,
    output logic [MW-1:0]      mul_b
);
    logic [DW-1:0] opa_q, opb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            opa_q <= '0;
            opb_q <= '0;
        end else begin
            opa_q <= opa_i;
            opb_q <= opb_i;
        end
    end

    always_comb begin
        add_a   = opa_q & {DW{en_i[U_ADD]}};
        add_b   = opb_q & {DW{en_i[U_ADD]}};
        shf_a   = opa_q & {DW{en_i[U_SHF]}};
        shf_amt = opb_q[SW-1:0] & {SW{en_i[U_SHF]}};
        mul_a   = opa_q[MW-1:0] & {MW{en_i[U_MUL]}};
        mul_b   = opb_q[MW-1:0] & {MW{en_i[U_MUL]}};
    end
endmodule

// File: rtl/exu_units.sv
module exu_units
    import exu_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int MW = MUL_W,
    parameter int SW = AMT_W
) (
    input  logic [DW-1:0] add_a,
    input  logic [DW-1:0] add_b,
    input  logic          sub,
    input  logic [DW-1:0] shf_a,
    input  logic [SW-1:0] shf_amt,
    input  shmode_e       shmode,
    input  logic [MW-1:0] mul_a,
    input  logic [MW-1:0] mul_b,
    output logic [DW-1:0] add_y,
    output logic [DW-1:0] shf_y,
    output logic [DW-1:0] mul_y
);
    logic [DW-1:0] mul_ax, mul_bx;

    always_comb begin
        add_y = sub ? (add_a - add_b) : (add_a + add_b);
    end

    always_comb begin
        case (shmode)
            SH_LEFT: shf_y = shf_a << shf_amt;
            SH_RLOG: shf_y = shf_a >> shf_amt;
            SH_RARI: shf_y = DW'($signed(shf_a) >>> shf_amt);
            default: shf_y = '0;
        endcase
    end

    always_comb begin
        mul_ax = DW'(mul_a);
        mul_bx = DW'(mul_b);
        mul_y  = mul_ax * mul_bx;
    end
endmodule

// File: rtl/exu_cluster.sv
module exu_cluster
    import exu_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int MW = MUL_W,
    parameter int SW = AMT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [3:0]         opcode_i,
    input  logic [DW-1:0]      opa_i,
    input  logic [DW-1:0]      opb_i,
    output logic [N_UNITS-1:0] unit_en_o,
    output logic [N_UNITS-1:0] pwr_full_o,
    output logic [DW-1:0]      add_a_o,
    output logic [DW-1:0]      add_b_o,
    output logic [DW-1:0]      shf_a_o,
    output logic [SW-1:0]      shf_amt_o,
    output logic [MW-1:0]      mul_a_o,
    output logic [MW-1:0]      mul_b_o,
    output logic [DW-1:0]      result_o,
    output logic               valid_o
);
    dec_t          dec_q;
    logic [DW-1:0] add_y, shf_y, mul_y;
    logic [DW-1:0] res_d;

    exu_decode u_dec (
        .clk(clk), .rst(rst), .opcode_i(opcode_i),
        .dec_q(dec_q), .pwr_q(pwr_full_o)
    );

    exu_isolate #(.DW(DW), .MW(MW), .SW(SW)) u_iso (
        .clk(clk), .rst(rst), .opa_i(opa_i), .opb_i(opb_i),
        .en_i(dec_q.en),
        .add_a(add_a_o), .add_b(add_b_o),
        .shf_a(shf_a_o), .shf_amt(shf_amt_o),
        .mul_a(mul_a_o), .mul_b(mul_b_o)
    );

    exu_units #(.DW(DW), .MW(MW), .SW(SW)) u_fu (
        .add_a(add_a_o), .add_b(add_b_o), .sub(dec_q.sub),
        .shf_a(shf_a_o), .shf_amt(shf_amt_o), .shmode(dec_q.shmode),
        .mul_a(mul_a_o), .mul_b(mul_b_o),
        .add_y(add_y), .shf_y(shf_y), .mul_y(mul_y)
    );

    assign unit_en_o = dec_q.en;

    always_comb begin
        res_d = '0;
        if (dec_q.en[U_ADD]) res_d = add_y;
        if (dec_q.en[U_SHF]) res_d = shf_y;
        if (dec_q.en[U_MUL]) res_d = mul_y;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result_o <= '0;
            valid_o  <= 1'b0;
        end else begin
            result_o <= res_d;
            valid_o  <= |dec_q.en;
        end
    end
endmodule

// File: rtl/exu_cluster_chk.sv
module exu_cluster_chk
    import exu_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [3:0]         opcode_i,
    input logic [N_UNITS-1:0] unit_en_o,
    input logic [N_UNITS-1:0] pwr_full_o,
    input logic [DATA_W-1:0]  add_a_o,
    input logic [DATA_W-1:0]  add_b_o,
    input logic [DATA_W-1:0]  shf_a_o,
    input logic [AMT_W-1:0]   shf_amt_o,
    input logic [MUL_W-1:0]   mul_a_o,
    input logic [MUL_W-1:0]   mul_b_o,
    input logic [DATA_W-1:0]  result_o,
    input logic               valid_o
);
    assert_en_onehot_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(unit_en_o));

    assert_add_idle_zero_R4: assert property (@(posedge clk) disable iff (rst)
        !unit_en_o[U_ADD] |-> (add_a_o == '0 && add_b_o == '0));

    assert_shf_idle_zero_R4: assert property (@(posedge clk) disable iff (rst)
        !unit_en_o[U_SHF] |-> (shf_a_o == '0 && shf_amt_o == '0));

    assert_mul_idle_zero_R4: assert property (@(posedge clk) disable iff (rst)
        !unit_en_o[U_MUL] |-> (mul_a_o == '0 && mul_b_o == '0));

    assert_pwr_follows_en_R5: assert property (@(posedge clk) disable iff (rst)
        pwr_full_o == unit_en_o);

    assert_undef_no_en_R6: assert property (@(posedge clk) disable iff (rst)
        (opcode_i == 4'h0 || opcode_i > 4'h6) |=> unit_en_o == '0);

    assert_idle_result_R6: assert property (@(posedge clk) disable iff (rst)
        (unit_en_o == '0) |=> (!valid_o && result_o == '0));

    assert_valid_follows_R7: assert property (@(posedge clk) disable iff (rst)
        (unit_en_o != '0) |=> valid_o);

    assert_reset_state_R10: assert property (@(posedge clk)
        rst |=> (unit_en_o == '0 && pwr_full_o == '0 && !valid_o && result_o == '0));
endmodule

bind exu_cluster exu_cluster_chk u_chk (
    .clk(clk), .rst(rst), .opcode_i(opcode_i),
    .unit_en_o(unit_en_o), .pwr_full_o(pwr_full_o),
    .add_a_o(add_a_o), .add_b_o(add_b_o),
    .shf_a_o(shf_a_o), .shf_amt_o(shf_amt_o),
    .mul_a_o(mul_a_o), .mul_b_o(mul_b_o),
    .result_o(result_o), .valid_o(valid_o)
);

// File: tb/tb_exu_cluster.sv
module tb_exu_cluster;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  opcode_i = 4'h0;
    logic [31:0] opa_i = '0, opb_i = '0;
    logic [2:0]  unit_en_o, pwr_full_o;
    logic [31:0] add_a_o, add_b_o, shf_a_o, result_o;
    logic [4:0]  shf_amt_o;
    logic [15:0] mul_a_o, mul_b_o;
    logic        valid_o;

    int n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    exu_cluster dut (
        .clk(clk), .rst(rst), .opcode_i(opcode_i), .opa_i(opa_i), .opb_i(opb_i),
        .unit_en_o(unit_en_o), .pwr_full_o(pwr_full_o),
        .add_a_o(add_a_o), .add_b_o(add_b_o), .shf_a_o(shf_a_o), .shf_amt_o(shf_amt_o),
        .mul_a_o(mul_a_o), .mul_b_o(mul_b_o), .result_o(result_o), .valid_o(valid_o)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] ref_en(input logic [3:0] op);
        case (op)
            4'h1, 4'h2: return 3'b001;
            4'h3, 4'h4, 4'h5: return 3'b010;
            4'h6: return 3'b100;
            default: return 3'b000;
        endcase
    endfunction

    function automatic logic [31:0] ref_res(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] r;
        int amt;
        amt = int'(b[4:0]);
        r = a;
        case (op)
            4'h1: return a + b;
            4'h2: return a - b;
            4'h3: begin for (int i = 0; i < amt; i++) r = {r[30:0], 1'b0}; return r; end
            4'h4: begin for (int i = 0; i < amt; i++) r = {1'b0, r[31:1]}; return r; end
            4'h5: begin for (int i = 0; i < amt; i++) r = {r[31], r[31:1]}; return r; end
            4'h6: return {16'h0, a[15:0]} * {16'h0, b[15:0]};
            default: return 32'h0;
        endcase
    endfunction

    // Checks enables, supply requests and isolated operands for the captured instruction.
    task automatic check_stage1(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b, input string req);
        logic [2:0] e;
        e = ref_en(op);
        check(unit_en_o == e, {req, " R1/R3 enables"}, 64'(unit_en_o), 64'(e));
        check(pwr_full_o == e, "R5 supply request", 64'(pwr_full_o), 64'(e));
        check(add_a_o == (e[0] ? a : 32'h0) && add_b_o == (e[0] ? b : 32'h0),
              "R4/R11 adder operands", {add_a_o, add_b_o}, {e[0] ? a : 32'h0, e[0] ? b : 32'h0});
        check(shf_a_o == (e[1] ? a : 32'h0) && shf_amt_o == (e[1] ? b[4:0] : 5'h0),
              "R4/R11 shifter operands", {27'h0, shf_amt_o, shf_a_o}, {27'h0, e[1] ? b[4:0] : 5'h0, e[1] ? a : 32'h0});
        check(mul_a_o == (e[2] ? a[15:0] : 16'h0) && mul_b_o == (e[2] ? b[15:0] : 16'h0),
              "R4/R11 multiplier operands", {32'h0, mul_a_o, mul_b_o}, {32'h0, e[2] ? a[15:0] : 16'h0, e[2] ? b[15:0] : 16'h0});
    endtask

    task automatic check_result(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b, input string req);
        logic [31:0] r;
        r = ref_res(op, a, b);
        check(result_o == r, {req, " result"}, 64'(result_o), 64'(r));
        check(valid_o == (ref_en(op) != 3'b000), "R7/R6 valid", 64'(valid_o), 64'(ref_en(op) != 3'b000));
    endtask

    // One instruction followed by a NOP; called at a negative edge.
    task automatic run_op(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b, input string req);
        opcode_i = op; opa_i = a; opb_i = b;
        @(negedge clk);
        check_stage1(op, a, b, req);
        opcode_i = 4'h0; opa_i = 32'hA5A5_5A5A; opb_i = 32'h5A5A_A5A5;
        @(negedge clk);
        check_result(op, a, b, req);
        check_stage1(4'h0, 32'h0, 32'h0, "R4 idle after op");
    endtask

    task automatic t_reset;
        rst = 1'b1;
        opcode_i = 4'h1; opa_i = 32'hFFFF_FFFF; opb_i = 32'h1;
        repeat (2) @(negedge clk);
        check(unit_en_o == 3'b000 && pwr_full_o == 3'b000, "R10 reset enables/supply",
              {58'h0, unit_en_o, pwr_full_o}, 64'h0);
        check(result_o == 32'h0 && !valid_o, "R10 reset result", {31'h0, valid_o, result_o}, 64'h0);
        check(add_a_o == 0 && shf_a_o == 0 && mul_a_o == 0, "R10 reset operands", 64'(add_a_o), 64'h0);
        opcode_i = 4'h0;
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_adder;
        run_op(4'h1, 32'h0000_1234, 32'h0000_4321, "R2 add");
        run_op(4'h1, 32'hFFFF_FFFF, 32'h0000_0002, "R2 add wrap");
        run_op(4'h2, 32'h0000_0005, 32'h0000_0009, "R2 sub borrow");
        run_op(4'h2, 32'h8000_0000, 32'h0000_0001, "R2 sub");
    endtask

    task automatic t_shifter;
        run_op(4'h3, 32'h0000_0001, 32'hFFFF_FFE4, "R9 sll amt from low bits");
        run_op(4'h4, 32'h8000_0000, 32'h0000_001F, "R9 srl 31");
        run_op(4'h5, 32'h8000_0000, 32'h0000_001F, "R9 sra 31");
        run_op(4'h5, 32'h4000_0010, 32'h0000_0004, "R9 sra positive");
        run_op(4'h3, 32'hDEAD_BEEF, 32'h0000_0000, "R9 shift by zero");
    endtask

    task automatic t_mul;
        run_op(4'h6, 32'h0000_FFFF, 32'h0000_FFFF, "R8 max product");
        run_op(4'h6, 32'hABCD_0003, 32'h1234_0007, "R8 upper bits ignored");
        run_op(4'h6, 32'h0000_0000, 32'h0000_7777, "R8 zero");
    endtask

    task automatic t_nop_undef;
        for (int op = 0; op < 16; op++) begin
            if (op == 0 || op > 6)
                run_op(4'(op), 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R6 nop/undefined");
        end
    endtask

    task automatic t_back_to_back;
        logic [3:0] ops [4] = '{4'h1, 4'h6, 4'h5, 4'h2};
        logic [31:0] as [4] = '{32'h10, 32'h0001_0100, 32'hF000_0000, 32'h7};
        logic [31:0] bs [4] = '{32'h20, 32'h0000_0100, 32'h0000_0008, 32'h9};
        opcode_i = ops[0]; opa_i = as[0]; opb_i = bs[0];
        @(negedge clk);
        for (int k = 1; k < 5; k++) begin
            check_stage1(ops[k-1], as[k-1], bs[k-1], "R1 back-to-back");
            if (k < 4) begin
                opcode_i = ops[k]; opa_i = as[k]; opb_i = bs[k];
            end else begin
                opcode_i = 4'h0;
            end
            @(negedge clk);
            check_result(ops[k-1], as[k-1], bs[k-1], "R7 back-to-back");
        end
    endtask

    task automatic t_hold_idle;
        opcode_i = 4'h4; opa_i = 32'hFFFF_0000; opb_i = 32'h0000_0003;
        @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            check_stage1(4'h4, 32'hFFFF_0000, 32'h3, "R4 idle held over cycles");
            opa_i = opa_i + 32'h11; opb_i = 32'h0000_0003;
            @(negedge clk);
            check_result(4'h4, opa_i - 32'h11, 32'h3, "R9 repeated srl");
            opa_i = 32'hFFFF_0000;
            check_stage1(4'h4, 32'hFFFF_0011, 32'h3, "R4 stage after change");
            @(negedge clk);
        end
        opcode_i = 4'h0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        fork
            begin
                @(negedge clk);
                t_reset();
                t_adder();
                t_shifter();
                t_mul();
                t_nop_undef();
                t_back_to_back();
                t_hold_idle();
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule